// File: doc/BRIEF.md
# Real-Mode Address Bit-20 Mask Unit

This unit sits in the address path of a processor core. It reproduces the wrap-around at the 1 MB boundary that real-mode software expects. While an external mask request is active and the core runs in real mode, the unit clears physical address bit 20. It applies this to the address that goes to the internal cache lookup and to the address that goes to the external bus request. In every other case both addresses pass through untouched.

The mask request is active low and arrives asynchronously to the core clock. A two-stage synchronizer brings it into the clock domain. A system may also change the request as a side effect of an I/O write. For that case, the unit samples the request directly on the clock edge where the I/O write completes with an active-low target-ready. It loads that value into its state and into the synchronizer. The accesses after the write therefore see the new setting with no synchronizer delay.

The mask state is a two-state machine. State `ST_CLEAR` means masking is off and state `ST_WRAP` means masking is on. From `ST_CLEAR` there are two ways into `ST_WRAP`:
- `T_IO_SET`: an I/O write completes while the request is low.
- `T_SYNC_SET`: the synchronized request reads active, and no I/O write completes on that edge.

From `ST_WRAP` there are two ways back to `ST_CLEAR`:
- `T_IO_CLR`: an I/O write completes while the request is high.
- `T_SYNC_CLR`: the synchronized request reads inactive, and no I/O write completes on that edge.

When an I/O write completes on an edge, its sample takes priority over the synchronizer. Reset enters `ST_CLEAR`.

Top module: `a20_wrap_unit`

## Requirements
- R1: When the mask state is on and `real_mode` is 1, `cache_addr_o` equals `cache_addr_i` with bit 20 forced to 0.
- R2: Under the same condition, `bus_addr_o` equals `bus_addr_i` with bit 20 forced to 0.
- R3: When `real_mode` is 0, both outputs equal their inputs, whatever the mask state.
- R4: Every output bit other than bit 20 always equals the matching input bit. An address whose bit 20 is already 0 is never altered.
- R5: Suppose `mask_req_n` changes level between clock edges with no I/O write completing. The outputs still show the old setting after the second rising edge. They show the new setting after the third rising edge.
- R6: On a rising edge where `io_wr` is 1 and `trdy_n` is 0, the mask state takes the inverse of `mask_req_n`. This applies to both setting and clearing. Accesses presented after that edge use the new setting.
- R7: A low `trdy_n` with `io_wr` at 0 captures nothing. A mask change then follows only the synchronized path of R5, so it has no effect one edge later.
- R8: After reset the mask state is off, and both outputs equal their inputs even in real mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| mask_req_n | input | 1 | Asynchronous active-low bit-20 mask request |
| real_mode | input | 1 | 1 while the core runs in real mode |
| io_wr | input | 1 | 1 while the current bus transaction is an I/O write |
| trdy_n | input | 1 | Active-low target-ready of the current bus transaction |
| cache_addr_i | input | AW | Physical address for the cache lookup, from the core |
| cache_addr_o | output | AW | Address presented to the cache lookup |
| bus_addr_i | input | AW | Physical address for the bus request, from the core |
| bus_addr_o | output | AW | Address presented to the bus request |

## Verification
A wrong mask state shows up as bit 20 of both outputs being wrong in real mode. The error appears on the first access after the edge that should have changed the state, and stays until a later transition. A synchronizer that is too short or too long shifts the change of setting by one edge relative to the third-edge rule. An I/O capture that is lost or gated by the wrong strobe shows up on the access right after the write edge. The bench probes each of these at exactly the edge where it matters, and reads all other bits to catch corruption beyond bit 20.

// File: rtl/a20_wrap_pkg.sv
package a20_wrap_pkg;

    // Bit position whose clearing folds addresses at the 1 MB boundary.
    localparam int unsigned WRAP_BIT = 20;

    // Minimum physical address width supported by the unit.
    localparam int unsigned MIN_AW = 32;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_WRAP  = 1'b1
    } a20_state_e;

endpackage

// File: rtl/a20_req_sync.sv
module a20_req_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    input  logic load_i,
    input  logic load_val_i,
    output logic sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        chain_q[g] <= 1'b0;
                    end else if (load_i) begin
                        chain_q[g] <= load_val_i;
                    end else begin
                        chain_q[g] <= async_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        chain_q[g] <= 1'b0;
                    end else if (load_i) begin
                        chain_q[g] <= load_val_i;
                    end else begin
                        chain_q[g] <= chain_q[g-1];
                    end
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];

    // A capture leaves the whole chain agreeing with the captured level (R6)
    AST_LOAD_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sync_o == $past(load_val_i)));  // R6

endmodule

// File: rtl/a20_mask_ctrl.sv
module a20_mask_ctrl
    import a20_wrap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_raw_i,
    input  logic req_sync_i,
    input  logic capture_i,
    output logic mask_on_o
);
    a20_state_e state_q;
    a20_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (capture_i) begin
                    if (req_raw_i) state_d = ST_WRAP;       // T_IO_SET
                end else if (req_sync_i) begin
                    state_d = ST_WRAP;                      // T_SYNC_SET
                end
            end
            ST_WRAP: begin
                if (capture_i) begin
                    if (!req_raw_i) state_d = ST_CLEAR;     // T_IO_CLR
                end else if (!req_sync_i) begin
                    state_d = ST_CLEAR;                     // T_SYNC_CLR
                end
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        mask_on_o = (state_q == ST_WRAP);
    end

    AST_IO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (mask_on_o == $past(req_raw_i)));  // R6

    AST_SYNC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(capture_i) && (mask_on_o != $past(mask_on_o)))
            |-> (mask_on_o == $past(req_sync_i)));  // R5

endmodule

// File: rtl/a20_addr_gate.sv
module a20_addr_gate
    import a20_wrap_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          fold_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] FOLD_MASK = ~(AW'(1) << WRAP_BIT);

    always_comb begin
        addr_o = fold_i ? (addr_i & FOLD_MASK) : addr_i;
    end

    always_comb begin
        AST_OTHER_BITS_KEPT: assert (((addr_o ^ addr_i) & FOLD_MASK) == '0);  // R4
    end

endmodule

// File: rtl/a20_wrap_unit.sv
module a20_wrap_unit
    import a20_wrap_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_req_n,
    input  logic          real_mode,
    input  logic          io_wr,
    input  logic          trdy_n,
    input  logic [AW-1:0] cache_addr_i,
    output logic [AW-1:0] cache_addr_o,
    input  logic [AW-1:0] bus_addr_i,
    output logic [AW-1:0] bus_addr_o
);
    localparam int unsigned AW_CHECKED = (AW < MIN_AW) ? MIN_AW : AW;
    localparam logic [AW-1:0] BIT_SEL  = AW'(1) << WRAP_BIT;

    logic req_raw;
    logic req_sync;
    logic capture;
    logic mask_on;
    logic fold;

    always_comb begin
        req_raw = ~mask_req_n;
        capture = io_wr & ~trdy_n;
    end

    a20_req_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_i   (req_raw),
        .load_i    (capture),
        .load_val_i(req_raw),
        .sync_o    (req_sync)
    );

    a20_mask_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_raw_i (req_raw),
        .req_sync_i(req_sync),
        .capture_i (capture),
        .mask_on_o (mask_on)
    );

    always_comb begin
        fold = mask_on & real_mode;
    end

    a20_addr_gate #(
        .AW(AW_CHECKED == AW ? AW : AW)
    ) u_gate_cache (
        .fold_i(fold),
        .addr_i(cache_addr_i),
        .addr_o(cache_addr_o)
    );

    a20_addr_gate #(
        .AW(AW)
    ) u_gate_bus (
        .fold_i(fold),
        .addr_i(bus_addr_i),
        .addr_o(bus_addr_o)
    );

    AST_CACHE_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_on && real_mode) |-> ((cache_addr_o & BIT_SEL) == '0));  // R1

    AST_BUS_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_on && real_mode) |-> ((bus_addr_o & BIT_SEL) == '0));  // R2

    AST_PROTECTED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !real_mode |-> ((cache_addr_o == cache_addr_i) && (bus_addr_o == bus_addr_i)));  // R3

    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |-> !mask_on);  // R8

endmodule

// File: tb/a20_wrap_unit_tb.sv
module a20_wrap_unit_tb;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mask_req_n = 1'b1;
    logic          real_mode = 1'b1;
    logic          io_wr = 1'b0;
    logic          trdy_n = 1'b1;
    logic [AW-1:0] cache_addr_i = '0;
    logic [AW-1:0] bus_addr_i = '0;
    logic [AW-1:0] cache_addr_o;
    logic [AW-1:0] bus_addr_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    a20_wrap_unit #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mask_req_n(mask_req_n), .real_mode(real_mode),
        .io_wr(io_wr), .trdy_n(trdy_n),
        .cache_addr_i(cache_addr_i), .cache_addr_o(cache_addr_o),
        .bus_addr_i(bus_addr_i), .bus_addr_o(bus_addr_o)
    );

    // {real_mode, mask_on, cache address, bus address}
    localparam int NV = 8;
    localparam logic [65:0] VEC [NV] = '{
        {1'b1, 1'b1, 32'h0010_0000, 32'h0010_0000},
        {1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0012_3456},
        {1'b1, 1'b0, 32'h0010_0000, 32'h001F_FFFF},
        {1'b0, 1'b1, 32'h0010_0000, 32'hFFFF_FFFF},
        {1'b1, 1'b1, 32'h000F_FFFF, 32'h0000_0000},
        {1'b0, 1'b0, 32'hA5A5_A5A5, 32'h5A5A_5A5A},
        {1'b1, 1'b1, 32'h7FF0_0001, 32'h8010_8000},
        {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0030_0000}
    };

    function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] a, logic on, logic rm);
        return (on && rm) ? (a & ~(32'h1 << 20)) : a;
    endfunction

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Complete an I/O write whose target-ready edge samples the mask level.
    task automatic io_capture(logic mask_active);
        @(negedge clk);
        mask_req_n = ~mask_active;
        io_wr = 1'b1;
        trdy_n = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
        trdy_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R8: reset state, real mode, mask requested but not yet recognized
        mask_req_n = 1'b0;
        cache_addr_i = 32'h0010_1234;
        bus_addr_i = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        #1;
        check("R8 cache in reset", cache_addr_o, 32'h0010_1234);
        check("R8 bus in reset", bus_addr_o, 32'hFFFF_FFFF);
        mask_req_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R8 cache after reset", cache_addr_o, 32'h0010_1234);

        // Vector table: R1 R2 R3 R4 R6
        for (int i = 0; i < NV; i++) begin
            logic rm, on;
            logic [AW-1:0] ca, ba;
            {rm, on, ca, ba} = VEC[i];
            io_capture(on);
            real_mode = rm;
            cache_addr_i = ca;
            bus_addr_i = ba;
            #1;
            check("R1/R3/R4/R6 cache vector", cache_addr_o, expect_addr(ca, on, rm));
            check("R2/R3/R4/R6 bus vector", bus_addr_o, expect_addr(ba, on, rm));
        end

        // R5: asynchronous set, latency through the synchronizer
        io_capture(1'b0);
        real_mode = 1'b1;
        cache_addr_i = 32'h0010_0000;
        bus_addr_i = 32'h0010_0000;
        repeat (3) @(negedge clk);
        mask_req_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R5 set not before edge 3", cache_addr_o, 32'h0010_0000);
        @(negedge clk);
        #1;
        check("R5 set after edge 3", cache_addr_o, 32'h0000_0000);
        check("R5 bus set after edge 3", bus_addr_o, 32'h0000_0000);

        // R5: asynchronous clear
        mask_req_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R5 clear not before edge 3", bus_addr_o, 32'h0000_0000);
        @(negedge clk);
        #1;
        check("R5 clear after edge 3", bus_addr_o, 32'h0010_0000);

        // R7: target-ready without an I/O write captures nothing
        @(negedge clk);
        mask_req_n = 1'b0;
        trdy_n = 1'b0;
        io_wr = 1'b0;
        @(negedge clk);
        trdy_n = 1'b1;
        #1;
        check("R7 no capture without io_wr", cache_addr_o, 32'h0010_0000);
        repeat (3) @(negedge clk);
        #1;
        check("R7 sync path still applies", cache_addr_o, 32'h0000_0000);

        // R6: I/O write clears immediately while the old level sits in the synchronizer
        io_capture(1'b0);
        #1;
        check("R6 io clear next access", cache_addr_o, 32'h0010_0000);
        @(negedge clk);
        #1;
        check("R6 io clear holds", bus_addr_o, 32'h0010_0000);

        // R3: leaving real mode with the mask on passes the address unchanged
        io_capture(1'b1);
        real_mode = 1'b0;
        cache_addr_i = 32'h0FF0_0000;
        #1;
        check("R3 protected mode pass", cache_addr_o, 32'h0FF0_0000);
        real_mode = 1'b1;
        #1;
        check("R1 back in real mode", cache_addr_o, 32'h0FE0_0000);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule